// File: doc/BRIEF.md
# Streaming Channel Select Reorder Buffer

This block takes a stream of blocks, each carrying a fixed count of input channels one per beat, and emits per block a shorter or reordered block. Output position `i` carries the input channel whose index is held in entry `i` of a select map. A simple write port loads the map. The block's data goes into one page of a two-page store while the previous block is read from the other page in map order. The two pages trade roles whenever an input block ends.

Each output block keeps the sequence number and sync flag of the input block it came from, so downstream logic can stay aligned to the input timing. The output side uses a valid/ready handshake. A beat moves on a clock edge where both `out_valid` and `out_ready` are high. The memory-mapped and streaming sides share one clock.

Top module: `chsel_reorder`

## Requirements
- R1: After reset `out_valid` is low, the select map is the identity (entry i holds i), and no beat is presented until an input beat with `in_eop` high has been accepted.
- R2: Output position i of a block carries the data of input channel `map[i]` from the same input block. Channel c is the c-th valid beat counted from the `in_sop` beat.
- R3: A map write with `map_addr` below CH_SEL sets that entry. The map is sampled when a block ends, so a write affects the next block to be read and not the block already being read.
- R4: Map writes with `map_addr` at or above CH_SEL change no entry.
- R5: When the input eop beat is accepted on clock edge k, the first beat of that block is presented after edge k+1, as long as the output register is free.
- R6: Every output beat carries the `in_seq` value of its source block's sop beat. `out_sync` is high only on the sop beat of a block whose input sop beat had `in_sync` high.
- R7: Each output block has exactly CH_SEL beats, with `out_sop` on the first and `out_eop` on the last.
- R8: While `out_valid` is high and `out_ready` is low, all outputs hold still. With CH_SEL at most CH_IN/2, `out_ready` toggling every cycle and gaps in `in_valid`, no beat is lost or repeated.
- R9: With a reversed map, the last channel written into a page is the first one read, right after the swap, and the value read is correct.
- R10: Full selection (CH_SEL equal to CH_IN) streams back-to-back blocks with no loss.
- R11: With COMPLEX=1, bits [DW-1:0] are the real part and bits [2*DW-1:DW] the imaginary part, and each part is carried intact. With COMPLEX=0 the 2*DW-bit word is carried whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the map port and the stream |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Map write strobe |
| map_addr | input | clog2(CH_SEL)+1 | Output position to write |
| map_data | input | clog2(CH_IN) | Input channel index for that position |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | First beat of an input block |
| in_eop | input | 1 | Last beat of an input block |
| in_sync | input | 1 | Sync flag, taken on the sop beat |
| in_seq | input | SEQ_W | Block sequence number, taken on the sop beat |
| in_data | input | 2*DW | Sample (complex or plain word) |
| out_ready | input | 1 | Downstream ready |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | First beat of an output block |
| out_eop | output | 1 | Last beat of an output block |
| out_sync | output | 1 | Sync flag of the source block, on sop only |
| out_seq | output | SEQ_W | Sequence number of the source block |
| out_data | output | 2*DW | Selected sample |

## Verification
The first beat of a block is due two edges after the edge that accepts the input eop. The bench checks this directly: one cycle after that eop `out_valid` must still be low, and one cycle later it must be high. Later beats follow one per edge on which the output register is empty or being drained, so the bench does not predict them by cycle. Instead it captures every handshake at the falling edge and compares the captured list, in order, against values it works out from the map and the channel pattern. Map writes are timed relative to the eop edge, so that the block already being read and the block after it have known, different maps.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  // Index width for a count of n items (at least one bit).
  function automatic int idx_w(int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // Next index in a wrapping count 0 .. n-1.
  function automatic int wrap_inc(int v, int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // A map address is honoured only inside the selected range.
  function automatic bit addr_in_range(int a, int lim);
    return a < lim;
  endfunction

endpackage

// File: rtl/chsel_map.sv
module chsel_map #(
  parameter int CH_SEL = 12,
  parameter int CW     = 4,
  parameter int PW     = 4,
  parameter int AW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          commit,
  input  logic [PW-1:0] rd_pos,
  output logic [CW-1:0] rd_ch
);
  import chsel_pkg::*;

  logic [CW-1:0] shadow [CH_SEL];
  logic [CW-1:0] active [CH_SEL];
  logic          wr_ok;

  assign wr_ok = wr_en && addr_in_range(int'(wr_addr), CH_SEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CH_SEL; i++) begin
        shadow[i] <= CW'(i);
        active[i] <= CW'(i);
      end
    end else begin
      if (wr_ok) shadow[wr_addr[PW-1:0]] <= wr_data;
      if (commit) begin
        for (int i = 0; i < CH_SEL; i++) active[i] <= shadow[i];
      end
    end
  end

  assign rd_ch = active[rd_pos];
endmodule

// File: rtl/chsel_pages.sv
module chsel_pages #(
  parameter int CH_IN   = 16,
  parameter int DW      = 16,
  parameter bit COMPLEX = 1'b1,
  parameter int SEQ_W   = 16,
  parameter int CW      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_sop,
  input  logic            in_eop,
  input  logic            in_sync,
  input  logic [SEQ_W-1:0] in_seq,
  input  logic [2*DW-1:0] in_data,
  output logic            blk_done,
  output logic            done_page,
  output logic [SEQ_W-1:0] done_seq,
  output logic            done_sync,
  input  logic            rd_page,
  input  logic [CW-1:0]   rd_ch,
  output logic [2*DW-1:0] rd_data
);
  import chsel_pkg::*;

  logic            wr_page;
  logic [CW-1:0]   wr_idx, idx;
  logic [SEQ_W-1:0] cap_seq;
  logic            cap_sync;

  assign idx       = in_sop ? '0 : wr_idx;
  assign blk_done  = in_valid && in_eop;
  assign done_page = wr_page;
  assign done_seq  = in_sop ? in_seq : cap_seq;
  assign done_sync = in_sop ? in_sync : cap_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_page  <= 1'b0;
      wr_idx   <= '0;
      cap_seq  <= '0;
      cap_sync <= 1'b0;
    end else if (in_valid) begin
      wr_idx <= in_eop ? '0 : CW'(wrap_inc(int'(idx), CH_IN));
      if (in_sop) begin
        cap_seq  <= in_seq;
        cap_sync <= in_sync;
      end
      if (in_eop) wr_page <= ~wr_page;
    end
  end

  generate
    if (COMPLEX) begin : g_cplx
      logic [DW-1:0] re_q [2][CH_IN];
      logic [DW-1:0] im_q [2][CH_IN];
      always_ff @(posedge clk) begin
        if (in_valid) begin
          re_q[wr_page][idx] <= in_data[DW-1:0];
          im_q[wr_page][idx] <= in_data[2*DW-1:DW];
        end
      end
      assign rd_data = {im_q[rd_page][rd_ch], re_q[rd_page][rd_ch]};
    end else begin : g_word
      logic [2*DW-1:0] wd_q [2][CH_IN];
      always_ff @(posedge clk) begin
        if (in_valid) wd_q[wr_page][idx] <= in_data;
      end
      assign rd_data = wd_q[rd_page][rd_ch];
    end
  endgenerate
endmodule

// File: rtl/chsel_reader.sv
module chsel_reader #(
  parameter int CH_SEL = 12,
  parameter int PW     = 4,
  parameter int W      = 32,
  parameter int SEQ_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_page,
  input  logic [SEQ_W-1:0] start_seq,
  input  logic            start_sync,
  output logic [PW-1:0]   rd_pos,
  output logic            rd_page,
  input  logic [W-1:0]    rd_data,
  output logic            beat_load,
  input  logic            out_ready,
  output logic            out_valid,
  output logic            out_sop,
  output logic            out_eop,
  output logic            out_sync,
  output logic [SEQ_W-1:0] out_seq,
  output logic [W-1:0]    out_data
);
  import chsel_pkg::*;

  localparam logic [PW-1:0] LAST = PW'(CH_SEL - 1);

  logic            busy;
  logic [PW-1:0]   pos;
  logic            page;
  logic [SEQ_W-1:0] seq_r;
  logic            sync_r;

  assign rd_pos    = pos;
  assign rd_page   = page;
  assign beat_load = busy && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pos       <= '0;
      page      <= 1'b0;
      seq_r     <= '0;
      sync_r    <= 1'b0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_sync  <= 1'b0;
      out_seq   <= '0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (beat_load) begin
        out_valid <= 1'b1;
        out_data  <= rd_data;
        out_sop   <= (pos == '0);
        out_eop   <= (pos == LAST);
        out_sync  <= sync_r && (pos == '0);
        out_seq   <= seq_r;
        pos       <= PW'(wrap_inc(int'(pos), CH_SEL));
        if (pos == LAST) busy <= 1'b0;
      end
      if (start) begin
        busy   <= 1'b1;
        pos    <= '0;
        page   <= start_page;
        seq_r  <= start_seq;
        sync_r <= start_sync;
      end
    end
  end
endmodule

// File: rtl/chsel_reorder.sv
module chsel_reorder #(
  parameter int CH_IN   = 16,
  parameter int CH_SEL  = 12,
  parameter int DW      = 16,
  parameter bit COMPLEX = 1'b1,
  parameter int SEQ_W   = 16,
  localparam int CW     = chsel_pkg::idx_w(CH_IN),
  localparam int PW     = chsel_pkg::idx_w(CH_SEL),
  localparam int MAP_AW = PW + 1,
  localparam int W      = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_we,
  input  logic [MAP_AW-1:0] map_addr,
  input  logic [CW-1:0]     map_data,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_sync,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic [W-1:0]      in_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_sync,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [W-1:0]      out_data
);
  // Named internal events (also used by the bound checker).
  logic             blk_done;
  logic             done_page;
  logic [SEQ_W-1:0] done_seq;
  logic             done_sync;
  logic [PW-1:0]    rd_pos;
  logic             rd_page;
  logic [CW-1:0]    rd_ch;
  logic [W-1:0]     rd_data;
  logic             beat_load;

  chsel_map #(.CH_SEL(CH_SEL), .CW(CW), .PW(PW), .AW(MAP_AW)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(map_we), .wr_addr(map_addr),
    .wr_data(map_data), .commit(blk_done), .rd_pos(rd_pos), .rd_ch(rd_ch)
  );

  chsel_pages #(.CH_IN(CH_IN), .DW(DW), .COMPLEX(COMPLEX), .SEQ_W(SEQ_W), .CW(CW)) u_pages (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_sync(in_sync), .in_seq(in_seq), .in_data(in_data),
    .blk_done(blk_done), .done_page(done_page), .done_seq(done_seq),
    .done_sync(done_sync), .rd_page(rd_page), .rd_ch(rd_ch), .rd_data(rd_data)
  );

  chsel_reader #(.CH_SEL(CH_SEL), .PW(PW), .W(W), .SEQ_W(SEQ_W)) u_reader (
    .clk(clk), .rst_n(rst_n), .start(blk_done), .start_page(done_page),
    .start_seq(done_seq), .start_sync(done_sync), .rd_pos(rd_pos),
    .rd_page(rd_page), .rd_data(rd_data), .beat_load(beat_load),
    .out_ready(out_ready), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_sync(out_sync), .out_seq(out_seq),
    .out_data(out_data)
  );
endmodule

// File: rtl/chsel_reorder_chk.sv
module chsel_reorder_chk #(
  parameter int CH_SEL = 12,
  parameter int W      = 32,
  parameter int SEQ_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             blk_done,
  input logic             out_ready,
  input logic             out_valid,
  input logic             out_sop,
  input logic             out_eop,
  input logic             out_sync,
  input logic [SEQ_W-1:0] out_seq,
  input logic [W-1:0]     out_data
);
  localparam int PW = chsel_pkg::idx_w(CH_SEL);
  localparam logic [PW-1:0] LAST = PW'(CH_SEL - 1);

  logic          seen_blk;
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_blk <= 1'b0;
      cnt      <= '0;
    end else begin
      if (blk_done) seen_blk <= 1'b1;
      if (out_valid && out_ready) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  AST_NO_EARLY_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_blk |-> !out_valid);                                           // R1
  AST_FIRST_BEAT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> ##1 out_valid);                                         // R5
  AST_SYNC_ONLY_ON_SOP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sync) |-> out_sop);                                // R6
  AST_FRAME_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_sop == (cnt == '0)) && (out_eop == (cnt == LAST)))); // R7
  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_seq)
      && $stable(out_sop) && $stable(out_eop) && $stable(out_sync)));    // R8
endmodule

bind chsel_reorder chsel_reorder_chk #(.CH_SEL(CH_SEL), .W(2 * DW), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_done(blk_done), .out_ready(out_ready),
  .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
  .out_sync(out_sync), .out_seq(out_seq), .out_data(out_data)
);

// File: tb/sim_chsel_reorder.sv
`timescale 1ns/1ps
module sim_chsel_reorder;
  localparam int CIN = 8;
  localparam int CSEL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        map_we = 1'b0;
  logic [2:0]  map_addr = '0;
  logic [2:0]  map_data = '0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_sync = 1'b0;
  logic [15:0] in_seq = '0;
  logic [31:0] in_data = '0;
  logic        out_ready = 1'b1;
  logic        out_valid, out_sop, out_eop, out_sync;
  logic [15:0] out_seq;
  logic [31:0] out_data;

  logic        f_valid, f_sop, f_eop, f_sync;
  logic [15:0] f_seq;
  logic [31:0] f_data;

  chsel_reorder #(.CH_IN(CIN), .CH_SEL(CSEL), .DW(16), .COMPLEX(1'b1), .SEQ_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_addr(map_addr), .map_data(map_data),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_sync(in_sync),
    .in_seq(in_seq), .in_data(in_data), .out_ready(out_ready), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_sync(out_sync), .out_seq(out_seq),
    .out_data(out_data));

  // Full-selection instance in plain-word mode (R10, R11)
  chsel_reorder #(.CH_IN(CIN), .CH_SEL(CIN), .DW(16), .COMPLEX(1'b0), .SEQ_W(16)) u1 (
    .clk(clk), .rst_n(rst_n), .map_we(1'b0), .map_addr(4'd0), .map_data(3'd0),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_sync(in_sync),
    .in_seq(in_seq), .in_data(in_data), .out_ready(1'b1), .out_valid(f_valid),
    .out_sop(f_sop), .out_eop(f_eop), .out_sync(f_sync), .out_seq(f_seq),
    .out_data(f_data));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit rmode = 1'b0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int seq, int ch);
    logic [15:0] re;
    re = 16'(seq * 16 + ch);
    return {re ^ 16'hA5A5, re};
  endfunction

  // map kinds: 0 identity, 1 reverse over input channels, 2 stride
  function automatic int mk(int kind, int i);
    case (kind)
      1: return CIN - 1 - i;
      2: return (3 * i + 1) % CIN;
      default: return i;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic map_wr(int a, int d);
    map_we = 1'b1; map_addr = 3'(a); map_data = 3'(d);
    tick();
    map_we = 1'b0;
  endtask

  task automatic load_map(int kind);
    for (int i = 0; i < CSEL; i++) map_wr(i, mk(kind, i));
  endtask

  task automatic send_beats(int seq, bit sync, bit gaps, int from, int upto, bit last);
    for (int ch = from; ch < upto; ch++) begin
      in_valid = 1'b1; in_sop = (ch == 0); in_eop = last && (ch == CIN - 1);
      in_sync = sync && (ch == 0); in_seq = 16'(seq); in_data = pat(seq, ch);
      tick();
      if (gaps && (ch % 3 == 1)) begin
        in_valid = 1'b0; tick();
      end
    end
    in_valid = 1'b0; in_eop = 1'b0; in_sop = 1'b0; in_sync = 1'b0;
  endtask

  // ready generator
  always @(posedge clk) begin
    #1;
    out_ready = rmode ? ~out_ready : 1'b1;
  end

  // capture of u0 handshakes
  logic [31:0] c_data [64];
  logic [15:0] c_seq  [64];
  bit          c_sop  [64], c_eop [64], c_sync [64];
  int ncap = 0;
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && ncap < 64) begin
      c_data[ncap] = out_data; c_seq[ncap] = out_seq;
      c_sop[ncap] = out_sop; c_eop[ncap] = out_eop; c_sync[ncap] = out_sync;
      ncap++;
    end
  end

  // u1 monitor: full selection, identity map, whole-word data
  int fpos = 0;
  always @(negedge clk) begin
    if (rst_n && f_valid) begin
      chk(f_data == pat(int'(f_seq), fpos), "R10 full-select data", f_data, pat(int'(f_seq), fpos));
      chk(f_sop == (fpos == 0) && f_eop == (fpos == CIN - 1), "R11 plain-word framing",
          {f_sop, f_eop}, {(fpos == 0), (fpos == CIN - 1)});
      fpos = (fpos == CIN - 1) ? 0 : fpos + 1;
    end
  end

  task automatic verify_blk(int base, int seq, bit sync, int kind, string req);
    for (int i = 0; i < CSEL; i++) begin
      chk(c_data[base + i] == pat(seq, mk(kind, i)), req, c_data[base + i], pat(seq, mk(kind, i)));
      chk(c_seq[base + i] == 16'(seq), "R6 seq", 32'(c_seq[base + i]), 32'(seq));
      chk(c_sync[base + i] == (sync && i == 0), "R6 sync", 32'(c_sync[base + i]), 32'(sync && i == 0));
      chk(c_sop[base + i] == (i == 0) && c_eop[base + i] == (i == CSEL - 1), "R7 framing",
          {c_sop[base + i], c_eop[base + i]}, {(i == 0), (i == CSEL - 1)});
    end
  endtask

  // stimulus table: map kind, ready toggling, input gaps
  localparam int NV = 4;
  localparam int VEC [NV][3] = '{'{0, 0, 0}, '{1, 1, 0}, '{2, 0, 1}, '{1, 1, 1}};

  initial begin
    #(5.0 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit quiet;
    repeat (4) tick();
    chk(out_valid == 1'b0, "R1 reset valid", 32'(out_valid), 0);
    rst_n = 1'b1;
    tick();
    // R1: partial block gives no output
    send_beats(1, 1'b1, 1'b0, 0, 5, 1'b0);
    quiet = 1'b1;
    for (int i = 0; i < 10; i++) begin
      if (out_valid) quiet = 1'b0;
      tick();
    end
    chk(quiet, "R1 no output before block end", 32'(!quiet), 0);
    // complete the block; R5 latency of first beat
    send_beats(1, 1'b1, 1'b0, 5, CIN, 1'b1);
    chk(out_valid == 1'b0, "R5 not yet valid", 32'(out_valid), 0);
    tick();
    chk(out_valid == 1'b1, "R5 first beat due", 32'(out_valid), 1);
    repeat (10) tick();
    chk(ncap == CSEL, "R7 beat count", 32'(ncap), 32'(CSEL));
    verify_blk(0, 1, 1'b1, 0, "R1 identity default map");

    // table walk: R2, R8, R9
    for (int v = 0; v < NV; v++) begin
      load_map(VEC[v][0]);
      rmode = VEC[v][1][0];
      ncap = 0;
      send_beats(10 + 2 * v, 1'b0, VEC[v][2][0], 0, CIN, 1'b1);
      send_beats(11 + 2 * v, 1'b1, VEC[v][2][0], 0, CIN, 1'b1);
      repeat (30) tick();
      rmode = 1'b0;
      chk(ncap == 2 * CSEL, "R8 no loss or repeat", 32'(ncap), 32'(2 * CSEL));
      verify_blk(0, 10 + 2 * v, 1'b0, VEC[v][0], VEC[v][0] == 1 ? "R9 reversed map" : "R2 select");
      verify_blk(CSEL, 11 + 2 * v, 1'b1, VEC[v][0], "R2 select second block");
    end

    // R4: out-of-range addresses change nothing
    load_map(0);
    map_wr(4, 6); map_wr(5, 6); map_wr(7, 5);
    ncap = 0;
    send_beats(30, 1'b0, 1'b0, 0, CIN, 1'b1);
    repeat (12) tick();
    verify_blk(0, 30, 1'b0, 0, "R4 ignored address");

    // R3: writes during readout apply to the following block only
    ncap = 0;
    send_beats(40, 1'b0, 1'b0, 0, CIN, 1'b1);
    load_map(1);
    send_beats(41, 1'b0, 1'b0, 0, CIN, 1'b1);
    repeat (12) tick();
    chk(ncap == 2 * CSEL, "R3 beat count", 32'(ncap), 32'(2 * CSEL));
    verify_blk(0, 40, 1'b0, 0, "R3 current block keeps old map");
    verify_blk(CSEL, 41, 1'b0, 1, "R3 next block uses new map");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule